// File: doc/BRIEF.md
# Shuffle-Buffer Block Address Relocator

The relocator sits on the miss path between a processor and memory. It keeps a repeated logical block address from showing up as the same physical address on the memory bus. A small on-chip buffer holds a fixed number of recently fetched blocks. A remap table gives the current physical home of every logical block, and it stores full-width addresses because a block may move anywhere in the program space.

A request that finds its block in the buffer is answered from the buffer. No memory traffic is issued. A request that misses reads its block from the physical address the table gives.

- While the buffer is still filling, the block takes the next free slot. The address it came from is kept as a vacated home.
- Once the buffer is full, every miss also forces exactly one write. A buffered block, chosen by an external random number, goes to the address just vacated. The new block takes that victim's slot, and the victim's table entry is updated.

A flush writes every buffered block back to the vacated homes and empties the buffer.

Top module: `shuffle_relocator`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, mem_rd, mem_wr and flush_done are 0. The remap table maps every logical block to the physical address of the same value.
- R2: A request whose logical address is held in the buffer returns that block's data with rsp_valid in the cycle after acceptance, and issues neither a memory read nor a memory write.
- R3: Buffer slots are numbered 0 to DEPTH-1. While fewer than DEPTH blocks are buffered, a miss issues exactly one read at the block's current physical address and no write. The block is placed in slot k, where k is the number of blocks buffered before it.
- R4: With the buffer full, a miss issues one read followed by exactly one write. The write goes to the same physical address that was read and carries the data of the block in the victim slot. The requested block then replaces the victim in that slot.
- R5: Occupancy never exceeds DEPTH, and a swap leaves it unchanged. A block just fetched is resident, so the next request for it hits.
- R6: After a swap, the victim's remap entry holds the address it was written to. A later miss on that block reads from there, and every response carries the data originally stored for the requested logical block.
- R7: From acceptance of a missing request until its response, req_ready is 0, so only one miss is outstanding.
- R8: A flush writes slot k's block to the k-th vacated address, in the order the slots were filled. It updates each block's remap entry, pulses flush_done and leaves the buffer empty, so the next request misses without a write.
- R9: The victim slot is rnd_in modulo DEPTH, sampled in the cycle the missing request is accepted. Later changes of rnd_in have no effect on that miss.
- R10: A flush of an empty buffer issues no write and still pulses flush_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Block request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | LA_W | Logical block address of the request |
| rnd_in | input | RND_W | Random number for victim choice |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Block data returned |
| mem_rd | output | 1 | Memory read command (one cycle) |
| mem_wr | output | 1 | Memory write command (one cycle) |
| mem_addr | output | LA_W | Physical block address of the command |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_rvalid | input | 1 | Read data valid |
| flush_req | input | 1 | Start a flush (taken while idle, ahead of requests) |
| flush_done | output | 1 | One-cycle pulse when the flush has finished |

## Verification
A corrupted remap entry or buffer slot shows up at the ports as a read at an unexpected physical address on the next miss of that block. It then shows up as wrong rsp_data on that same request. A wrong victim or vacated-address record shows up within the swap as a write whose address differs from the read just made, or whose data belongs to another slot. After a flush, it shows up as wrong memory contents at the vacated homes. A wrong occupancy count shows up as a write during filling, a missing write once full, or a hit that touches memory.

// File: rtl/srb_pkg.sv
// Shared types for the shuffle-buffer relocator.
package srb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RDREQ,
        ST_RDWAIT,
        ST_WR,
        ST_FLUSH
    } srb_state_t;
endpackage

// File: rtl/srb_remap_table.sv
// Logical-to-physical block address table.
// Each entry holds a full-width physical block address.
// Assumes one write port; the read is combinational.
// Reset loads the identity mapping.
module srb_remap_table #(
    parameter int LA_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LA_W-1:0] rd_log,
    output logic [LA_W-1:0] rd_phys,
    input  logic            wr_en,
    input  logic [LA_W-1:0] wr_log,
    input  logic [LA_W-1:0] wr_phys
);
    localparam int ENTRIES = 1 << LA_W;

    logic [LA_W-1:0] tab [ENTRIES];

    // Lookup of the current physical home.
    assign rd_phys = tab[rd_log];

    // Identity on reset, single-entry update otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tab[i] <= LA_W'(i);
            end
        end else if (wr_en) begin
            tab[wr_log] <= wr_phys;
        end
    end
endmodule

// File: rtl/srb_buffer.sv
// On-chip block buffer.
// Each slot holds a logical address, the block data and a vacated home address.
// Fill appends at slot index = occupancy; replace overwrites one slot and keeps its home.
// clr empties the buffer.
// Assumes the controller never fills when full.
module srb_buffer #(
    parameter int LA_W   = 6,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LA_W-1:0]   lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              ins_en,
    input  logic [LA_W-1:0]   ins_log,
    input  logic [DATA_W-1:0] ins_data,
    input  logic [LA_W-1:0]   ins_home,
    input  logic              rep_en,
    input  logic [IDX_W-1:0]  rep_idx,
    input  logic [LA_W-1:0]   rep_log,
    input  logic [DATA_W-1:0] rep_data,
    input  logic              clr,
    input  logic [IDX_W-1:0]  sel_idx,
    output logic [LA_W-1:0]   sel_log,
    output logic [DATA_W-1:0] sel_data,
    output logic [LA_W-1:0]   sel_home,
    output logic [CNT_W-1:0]  occ
);
    logic [LA_W-1:0]   slot_log  [DEPTH];
    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [LA_W-1:0]   slot_home [DEPTH];
    logic [DEPTH-1:0]  hit_vec;

    // Per-slot address compare, qualified by occupancy.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = (CNT_W'(g) < occ) && (slot_log[g] == lk_addr);
    end

    assign lk_hit = |hit_vec;

    // Data of the matching slot.
    always_comb begin
        lk_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) lk_data = slot_data[i];
        end
    end

    // Selected-slot read port for victim and flush.
    assign sel_log  = slot_log[sel_idx];
    assign sel_data = slot_data[sel_idx];
    assign sel_home = slot_home[sel_idx];

    // Occupancy and slot contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slot_log[i]  <= '0;
                slot_data[i] <= '0;
                slot_home[i] <= '0;
            end
        end else if (clr) begin
            occ <= '0;
        end else begin
            if (ins_en) begin
                slot_log[IDX_W'(occ)]  <= ins_log;
                slot_data[IDX_W'(occ)] <= ins_data;
                slot_home[IDX_W'(occ)] <= ins_home;
                occ <= occ + 1'b1;
            end
            if (rep_en) begin
                slot_log[rep_idx]  <= rep_log;
                slot_data[rep_idx] <= rep_data;
            end
        end
    end

    // R5: occupancy bounded by depth.
    a_r5_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    // R2: a logical block is held in at most one slot.
    a_r2_unique_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R3: filling only happens below full.
    a_r3_no_fill_full: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> (occ < CNT_W'(DEPTH)));
endmodule

// File: rtl/shuffle_relocator.sv
// Shuffle-buffer block address relocator (top).
// Serves hits from the buffer. A miss is read from the remapped address.
// When the buffer is full, the miss is followed by one forced write of a random victim
// to the vacated address, and the victim's remap entry is updated.
// A flush writes the buffer back to the vacated homes.
// Assumes memory answers each read with one mem_rvalid pulse; writes are posted.
module shuffle_relocator
    import srb_pkg::*;
#(
    parameter int LA_W   = 6,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int RND_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LA_W-1:0]   req_addr,
    input  logic [RND_W-1:0]  rnd_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [LA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    input  logic              flush_req,
    output logic              flush_done
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    srb_state_t        state;
    logic [LA_W-1:0]   cur_log;
    logic [LA_W-1:0]   cur_phys;
    logic [IDX_W-1:0]  vic_idx;
    logic [DATA_W-1:0] rd_data_q;
    logic [CNT_W-1:0]  fidx;

    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic [LA_W-1:0]   map_phys;
    logic              map_we;
    logic [LA_W-1:0]   map_wphys;
    logic              ins_en;
    logic              rep_en;
    logic              clr;
    logic              fl_wr;
    logic              full;
    logic [IDX_W-1:0]  sel_idx;
    logic [LA_W-1:0]   sel_log;
    logic [DATA_W-1:0] sel_data;
    logic [LA_W-1:0]   sel_home;
    logic [CNT_W-1:0]  occ;
    logic [IDX_W-1:0]  rnd_mod;
    logic              accept;

    // Control decode for buffer, table and memory port.
    always_comb begin
        full      = (occ == CNT_W'(DEPTH));
        rnd_mod   = IDX_W'(rnd_in % RND_W'(DEPTH));
        req_ready = (state == ST_IDLE) && !flush_req;
        accept    = req_valid && req_ready;
        fl_wr     = (state == ST_FLUSH) && (fidx < occ);
        ins_en    = (state == ST_RDWAIT) && mem_rvalid && !full;
        rep_en    = (state == ST_WR);
        clr       = (state == ST_FLUSH) && !fl_wr;
        sel_idx   = (state == ST_FLUSH) ? IDX_W'(fidx) : vic_idx;
        map_we    = rep_en || fl_wr;
        map_wphys = rep_en ? cur_phys : sel_home;
        mem_rd    = (state == ST_RDREQ);
        mem_wr    = rep_en || fl_wr;
        mem_addr  = (state == ST_FLUSH) ? sel_home : cur_phys;
        mem_wdata = sel_data;
    end

    srb_buffer #(
        .LA_W(LA_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
    ) buf_i (
        .clk(clk), .rst_n(rst_n),
        .lk_addr(req_addr), .lk_hit(lk_hit), .lk_data(lk_data),
        .ins_en(ins_en), .ins_log(cur_log), .ins_data(mem_rdata), .ins_home(cur_phys),
        .rep_en(rep_en), .rep_idx(vic_idx), .rep_log(cur_log), .rep_data(rd_data_q),
        .clr(clr),
        .sel_idx(sel_idx), .sel_log(sel_log), .sel_data(sel_data), .sel_home(sel_home),
        .occ(occ)
    );

    srb_remap_table #(
        .LA_W(LA_W)
    ) map_i (
        .clk(clk), .rst_n(rst_n),
        .rd_log(req_addr), .rd_phys(map_phys),
        .wr_en(map_we), .wr_log(sel_log), .wr_phys(map_wphys)
    );

    // Sequencer: hit response, read/swap pair, flush walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_log    <= '0;
            cur_phys   <= '0;
            vic_idx    <= '0;
            rd_data_q  <= '0;
            fidx       <= '0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            flush_done <= 1'b0;
        end else begin
            rsp_valid  <= 1'b0;
            flush_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (flush_req) begin
                        fidx  <= '0;
                        state <= ST_FLUSH;
                    end else if (accept) begin
                        if (lk_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= lk_data;
                        end else begin
                            cur_log  <= req_addr;
                            cur_phys <= map_phys;
                            vic_idx  <= rnd_mod;
                            state    <= ST_RDREQ;
                        end
                    end
                end
                ST_RDREQ: state <= ST_RDWAIT;
                ST_RDWAIT: begin
                    if (mem_rvalid) begin
                        if (full) begin
                            rd_data_q <= mem_rdata;
                            state     <= ST_WR;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= mem_rdata;
                            state     <= ST_IDLE;
                        end
                    end
                end
                ST_WR: begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= rd_data_q;
                    state     <= ST_IDLE;
                end
                ST_FLUSH: begin
                    if (fl_wr) begin
                        fidx <= fidx + 1'b1;
                    end else begin
                        flush_done <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: never a read and a write in the same cycle.
    a_r3_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2: an accepted hit causes no memory command next cycle.
    a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_hit) |=> (!mem_rd && !mem_wr));

    // R7: no request is taken while a read is outstanding.
    a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !req_ready);

    // R5: a swap write keeps occupancy constant.
    a_r5_swap_occ: assert property (@(posedge clk) disable iff (!rst_n)
        rep_en |=> (occ == $past(occ)));

    // R8: buffer is empty when a flush reports done.
    a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> (occ == '0));
endmodule

// File: tb/shuffle_relocator_tb.sv
`timescale 1ns/1ps
module shuffle_relocator_tb_top;
    localparam int LA_W   = 6;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 4;
    localparam int RND_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [LA_W-1:0]   req_addr = '0;
    logic [RND_W-1:0]  rnd_in = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              mem_rd, mem_wr;
    logic [LA_W-1:0]   mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_rvalid;
    logic              flush_req = 1'b0;
    logic              flush_done;

    int checks = 0;
    int failures = 0;

    // Bench memory model and traffic counters.
    logic [DATA_W-1:0] mem [1 << LA_W];
    int                rd_cnt, wr_cnt;
    logic [LA_W-1:0]   last_rd, last_wa;
    logic [DATA_W-1:0] last_wd;

    // Bench model of buffer residency (slot order from R3/R4).
    int m_slot [DEPTH];
    int m_cnt = 0;

    always #4 clk = ~clk;

    shuffle_relocator #(
        .LA_W(LA_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .RND_W(RND_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rnd_in(rnd_in),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .flush_req(flush_req), .flush_done(flush_done)
    );

    function automatic logic [DATA_W-1:0] cval(input int a);
        return DATA_W'(16'hA000 + a * 7);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1 << LA_W); i++) mem[i] <= cval(i);
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            rd_cnt     <= 0;
            wr_cnt     <= 0;
            last_rd    <= '0;
            last_wa    <= '0;
            last_wd    <= '0;
        end else begin
            mem_rvalid <= mem_rd;
            if (mem_rd) begin
                mem_rdata <= mem[mem_addr];
                rd_cnt    <= rd_cnt + 1;
                last_rd   <= mem_addr;
            end
            if (mem_wr) begin
                mem[mem_addr] <= mem_wdata;
                wr_cnt  <= wr_cnt + 1;
                last_wa <= mem_addr;
                last_wd <= mem_wdata;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One request; expectations come from the bench residency model.
    task automatic do_req(input int la, input int rnd, input int exp_rd, input string tag);
        int  rc, wc, n, hit_i, vic;
        bit  busy_ready;
        logic [DATA_W-1:0] exp_wd;
        hit_i = -1;
        for (int i = 0; i < m_cnt; i++) if (m_slot[i] == la) hit_i = i;
        vic = rnd % DEPTH;
        exp_wd = cval(m_slot[vic]);
        rc = rd_cnt;
        wc = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = LA_W'(la);
        rnd_in    = RND_W'(rnd);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rnd_in    = ~RND_W'(rnd);   // R9: later changes must not matter
        n = 0;
        busy_ready = 1'b0;
        while (!rsp_valid && n < 50) begin
            if (req_ready) busy_ready = 1'b1;
            @(negedge clk);
            n++;
        end
        chk(rsp_valid, {tag, " response present"}, int'(rsp_valid), 1);
        chk(rsp_data == cval(la), {tag, " R6 data"}, int'(rsp_data), int'(cval(la)));
        if (hit_i >= 0) begin
            chk(n == 0, "R2 hit latency", n, 0);
            chk(rd_cnt == rc && wr_cnt == wc, "R2 hit no memory",
                (rd_cnt - rc) + (wr_cnt - wc), 0);
        end else begin
            chk(!busy_ready, "R7 ready low while busy", int'(busy_ready), 0);
            chk(rd_cnt - rc == 1, "R3 one read", rd_cnt - rc, 1);
            if (exp_rd >= 0) chk(int'(last_rd) == exp_rd, {tag, " read address"},
                                 int'(last_rd), exp_rd);
            if (m_cnt < DEPTH) begin
                chk(wr_cnt == wc, "R3 no write while filling", wr_cnt - wc, 0);
                m_slot[m_cnt] = la;
                m_cnt++;
            end else begin
                chk(wr_cnt - wc == 1, "R4 one write", wr_cnt - wc, 1);
                chk(last_wa == last_rd, "R4 write to vacated address",
                    int'(last_wa), int'(last_rd));
                chk(last_wd == exp_wd, "R9 victim data", int'(last_wd), int'(exp_wd));
                m_slot[vic] = la;
            end
        end
    endtask

    task automatic do_flush(input string tag);
        int wc, n;
        wc = wr_cnt;
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        n = 0;
        while (!flush_done && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(flush_done, {tag, " done pulse"}, int'(flush_done), 1);
        chk(wr_cnt - wc == m_cnt, {tag, " write count"}, wr_cnt - wc, m_cnt);
        m_cnt = 0;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(!rsp_valid && !mem_rd && !mem_wr && !flush_done, "R1 outputs idle",
            int'({rsp_valid, mem_rd, mem_wr, flush_done}), 0);
    endtask

    task automatic t_fill();
        do_req(5, 0, 5, "R3 fill");
        do_req(17, 0, 17, "R3 fill");
        do_req(40, 0, 40, "R3 fill");
        do_req(63, 0, 63, "R3 fill");
        do_req(40, 0, -1, "R2 hit");
    endtask

    task automatic t_swap();
        do_req(9, 1, 9, "R4 swap");
        do_req(9, 0, -1, "R5 resident");
        do_req(17, 6, 9, "R6 remapped victim");
        do_req(40, 3, 9, "R6 remapped victim");
    endtask

    task automatic t_flush_full();
        do_flush("R8");
        chk(mem[5] == cval(5), "R8 slot0 home", int'(mem[5]), int'(cval(5)));
        chk(mem[17] == cval(9), "R8 slot1 home", int'(mem[17]), int'(cval(9)));
        chk(mem[40] == cval(17), "R8 slot2 home", int'(mem[40]), int'(cval(17)));
        chk(mem[63] == cval(40), "R8 slot3 home", int'(mem[63]), int'(cval(40)));
        chk(mem[9] == cval(63), "R6 victim home", int'(mem[9]), int'(cval(63)));
        do_req(9, 2, 17, "R8 empty after flush");
        do_req(63, 2, 9, "R6 remap after flush");
    endtask

    task automatic t_flush_empty();
        do_flush("R8 partial");
        do_flush("R10 empty");
    endtask

    task automatic t_sweep();
        for (int a = 0; a < 64; a += 5) do_req(a, a * 3 + 1, -1, "R6 sweep");
        do_req(10, 0, -1, "R6 sweep");
        do_flush("R8 final");
        do_req(9, 5, -1, "R6 final");
        do_req(63, 7, -1, "R6 final");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_swap();
        t_flush_full();
        t_flush_empty();
        t_sweep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule